// File: doc/BRIEF.md
# ADC Pair Completion Interrupt Collector

This block gathers conversion-finished strobes from a set of ADC input pairs and turns them into one combined interrupt. Each pair has an enable bit. When an enabled pair reports a finished conversion, the block does two things:

- It sets that pair's ready bit. The ready bit stays set until software clears it.
- It raises a one-cycle request, but only if the ready bit was clear before.

The request sets a latched interrupt flag, which stands in for the interrupt controller's pending bit. Only a software clear resets that flag.

Two software write strobes are provided. The first clears ready bits using a write-one-to-clear mask. The second clears the interrupt flag. A request is a single pulse aimed at a latched flag. Because of this, the order in which software clears the two decides whether a completion is noticed. Clearing the interrupt flag first is always safe. Clearing a ready bit first lets a later completion raise a request that merges into the flag, which is still set. The next flag clear then wipes that request out.

The enable vector is arranged as control words of two pairs each. Pairs 2k and 2k+1 share word k, but every bit acts only on its own pair.

Top module: `adc_grp_irq`

## Requirements
- R1: While reset is asserted and in the first cycle after it, every ready bit is 0, the request output is 0 and the interrupt flag is 0.
- R2: A completion strobe on pair i while enable bit i is 1 makes ready bit i read 1 from the next clock edge onward.
- R3: A completion strobe on pair i while enable bit i is 0 has no effect: the ready bits, the request output and the interrupt flag are left unchanged.
- R4: The request output is 1, combinationally in the same cycle, exactly when an enabled completion arrives for a pair whose ready bit is 0. A completion on a pair whose ready bit is already 1 raises no request.
- R5: A request sets the interrupt flag at the next clock edge. The flag then holds until a cycle in which the flag clear strobe is 1.
- R6: When the ready clear strobe is 1, each ready bit whose mask bit is 1 becomes 0 at the next edge, and every other ready bit keeps its value. When the strobe is 0, the mask has no effect.
- R7: If an enabled completion and a ready clear hit the same pair in the same cycle, that ready bit reads 1 afterwards.
- R8: If a request and a flag clear occur in the same cycle, the flag reads 1 afterwards.
- R9: Hardware never clears a ready bit; only the ready clear write does.
- R10: The sequence "clear ready bit, completion on that pair, clear flag" leaves the flag at 0 with the ready bit at 1. The sequence "clear flag, clear ready bit, completion on that pair" leaves the flag at 1.
- R11: Enabled completions on several pairs in one cycle set all their ready bits together and give a single request cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| done_i | input | NUM_PAIRS | Per-pair conversion-finished strobe |
| irq_en_i | input | NUM_PAIRS | Per-pair interrupt enable; bits 2k and 2k+1 form control word k |
| rdy_clr_we_i | input | 1 | Ready clear write strobe |
| rdy_clr_mask_i | input | NUM_PAIRS | Write-one-to-clear mask for the ready bits |
| flag_clr_i | input | 1 | Interrupt flag clear strobe |
| rdy_o | output | NUM_PAIRS | Ready status vector |
| irq_req_o | output | 1 | One-cycle combined interrupt request |
| irq_flag_o | output | 1 | Latched interrupt flag |

## Verification
The collection path is driven with several completion patterns, and each one separates a different behaviour:

- A lone enabled completion on a pair that is not ready separates request generation from ready setting.
- A completion repeated on a pair that is already ready shows that no second request appears.
- A completion with its enable low shows the enable gating.
- Simultaneous completions on several pairs show that the requests merge into one.

Collisions between a completion and each clear strobe in the same cycle reveal which side wins. The two software clear orderings are run back to back to show the lost-request case apart from the safe one.

// File: rtl/adc_grp_irq.sv
module adc_grp_irq #(
  parameter int NUM_PAIRS = 6
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_PAIRS-1:0] done_i,
  input  logic [NUM_PAIRS-1:0] irq_en_i,
  input  logic                 rdy_clr_we_i,
  input  logic [NUM_PAIRS-1:0] rdy_clr_mask_i,
  input  logic                 flag_clr_i,
  output logic [NUM_PAIRS-1:0] rdy_o,
  output logic                 irq_req_o,
  output logic                 irq_flag_o
);

  localparam int NUM_CTRL = (NUM_PAIRS + 1) / 2;

  logic [NUM_PAIRS-1:0] rdy_q;
  logic [NUM_PAIRS-1:0] hit;
  logic [NUM_PAIRS-1:0] clr_vec;
  logic [NUM_PAIRS-1:0] fresh;
  logic [2*NUM_CTRL-1:0] en_words;
  logic                 flag_q;

  // enable bits viewed as two-pair control words
  assign en_words = {{(2*NUM_CTRL-NUM_PAIRS){1'b0}}, irq_en_i};

  genvar g;
  generate
    for (g = 0; g < NUM_PAIRS; g++) begin : g_pair
      assign hit[g] = done_i[g] & en_words[2*(g/2) + (g%2)];
    end
  endgenerate

  assign clr_vec   = rdy_clr_we_i ? rdy_clr_mask_i : '0;
  assign fresh     = hit & ~rdy_q;
  assign irq_req_o = |fresh;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rdy_q  <= '0;
      flag_q <= 1'b0;
    end else begin
      rdy_q  <= (rdy_q & ~clr_vec) | hit;
      flag_q <= irq_req_o | (flag_q & ~flag_clr_i);
    end
  end

  assign rdy_o      = rdy_q;
  assign irq_flag_o = flag_q;

  AST_RDY_RESET: assert property (@(posedge clk) !rst_n |=> (rdy_o == '0 && !irq_flag_o)); // R1
  AST_RDY_ONLY_FROM_ENABLED: assert property (@(posedge clk) disable iff (!rst_n)
    ((rdy_o & ~$past(rdy_o) & ~$past(done_i & irq_en_i)) == '0)); // R3
  AST_REQ_NEEDS_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req_o |-> ((done_i & irq_en_i & ~rdy_o) != '0)); // R4
  AST_FLAG_ON_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req_o |=> irq_flag_o); // R5
  AST_FLAG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_flag_o && !flag_clr_i) |=> irq_flag_o); // R5
  AST_NO_HW_RDY_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (rdy_o & ~(rdy_clr_we_i ? rdy_clr_mask_i : '0)) == (rdy_o & ~(rdy_clr_we_i ? rdy_clr_mask_i : '0))
    |=> (($past(rdy_o) & ~$past(rdy_clr_we_i ? rdy_clr_mask_i : '0) & ~rdy_o) == '0)); // R9
  AST_SET_BEATS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (($past(done_i & irq_en_i) & ~rdy_o) == '0)); // R7

endmodule

// File: tb/adc_grp_irq_tb.sv
module adc_grp_irq_tb;
  localparam int N = 6;

  logic         clk = 1'b0;
  logic         rst_n;
  logic [N-1:0] done_i, irq_en_i, rdy_clr_mask_i;
  logic         rdy_clr_we_i, flag_clr_i;
  logic [N-1:0] rdy_o;
  logic         irq_req_o, irq_flag_o;

  int n_tests = 0;
  int n_fail  = 0;

  always #2.5 clk = ~clk;

  adc_grp_irq #(.NUM_PAIRS(N)) u_dut (
    .clk(clk), .rst_n(rst_n), .done_i(done_i), .irq_en_i(irq_en_i),
    .rdy_clr_we_i(rdy_clr_we_i), .rdy_clr_mask_i(rdy_clr_mask_i),
    .flag_clr_i(flag_clr_i), .rdy_o(rdy_o), .irq_req_o(irq_req_o),
    .irq_flag_o(irq_flag_o)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic idle();
    done_i = '0; rdy_clr_we_i = 1'b0; rdy_clr_mask_i = '0; flag_clr_i = 1'b0;
  endtask

  task automatic step();
    @(posedge clk); @(negedge clk); idle(); #1;
  endtask

  task automatic wipe();
    idle(); rdy_clr_we_i = 1'b1; rdy_clr_mask_i = '1; flag_clr_i = 1'b1; step();
  endtask

  task automatic t_reset();
    rst_n = 1'b0; idle(); irq_en_i = '1;
    @(posedge clk); @(negedge clk); #1;
    check("R1 rdy in reset", 32'(rdy_o), 0);
    check("R1 flag in reset", 32'(irq_flag_o), 0);
    rst_n = 1'b1; step();
    check("R1 rdy after reset", 32'(rdy_o), 0);
    check("R1 req after reset", 32'(irq_req_o), 0);
  endtask

  task automatic t_single();
    wipe();
    done_i = 6'b000001; #1;
    check("R4 req on fresh completion", 32'(irq_req_o), 1);
    step();
    check("R2 rdy set", 32'(rdy_o), 32'h01);
    check("R5 flag set", 32'(irq_flag_o), 1);
    check("R4 req one cycle", 32'(irq_req_o), 0);
    done_i = 6'b000001; #1;
    check("R4 no req when already ready", 32'(irq_req_o), 0);
    step(); step();
    check("R5 flag held", 32'(irq_flag_o), 1);
    check("R9 rdy held", 32'(rdy_o), 32'h01);
  endtask

  task automatic t_disabled();
    wipe();
    irq_en_i = 6'b111011;
    done_i = 6'b000100; #1;
    check("R3 no req when disabled", 32'(irq_req_o), 0);
    step();
    check("R3 rdy untouched", 32'(rdy_o), 0);
    check("R3 flag untouched", 32'(irq_flag_o), 0);
    irq_en_i = '1;
  endtask

  task automatic t_w1c();
    wipe();
    done_i = 6'b101101; step();
    rdy_clr_we_i = 1'b0; rdy_clr_mask_i = 6'b111111; step();
    check("R6 mask ignored without strobe", 32'(rdy_o), 32'h2D);
    rdy_clr_we_i = 1'b1; rdy_clr_mask_i = 6'b000101; step();
    check("R6 only masked bits cleared", 32'(rdy_o), 32'h28);
    check("R6 flag unaffected", 32'(irq_flag_o), 1);
  endtask

  task automatic t_collide_rdy();
    wipe();
    done_i = 6'b000010; step();
    done_i = 6'b000010; rdy_clr_we_i = 1'b1; rdy_clr_mask_i = 6'b000010; step();
    check("R7 set beats clear", 32'(rdy_o), 32'h02);
  endtask

  task automatic t_collide_flag();
    wipe();
    done_i = 6'b001000; flag_clr_i = 1'b1; #1;
    check("R8 req present", 32'(irq_req_o), 1);
    step();
    check("R8 flag wins over clear", 32'(irq_flag_o), 1);
    flag_clr_i = 1'b1; step();
    check("R5 flag cleared by strobe", 32'(irq_flag_o), 0);
  endtask

  task automatic t_order();
    wipe();
    done_i = 6'b000010; step();
    rdy_clr_we_i = 1'b1; rdy_clr_mask_i = 6'b000010; step();
    done_i = 6'b000010; step();
    flag_clr_i = 1'b1; step();
    check("R10 ready-first loses flag", 32'(irq_flag_o), 0);
    check("R10 ready bit still set", 32'(rdy_o), 32'h02);
    wipe();
    done_i = 6'b010000; step();
    flag_clr_i = 1'b1; step();
    rdy_clr_we_i = 1'b1; rdy_clr_mask_i = 6'b010000; step();
    done_i = 6'b010000; step();
    check("R10 flag-first keeps flag", 32'(irq_flag_o), 1);
  endtask

  task automatic t_multi();
    wipe();
    done_i = 6'b110011; #1;
    check("R11 req on multiple", 32'(irq_req_o), 1);
    step();
    check("R11 all ready bits", 32'(rdy_o), 32'h33);
    check("R11 single request cycle", 32'(irq_req_o), 0);
  endtask

  initial begin
    #200000;
    n_tests++; n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    t_reset();
    t_single();
    t_disabled();
    t_w1c();
    t_collide_rdy();
    t_collide_flag();
    t_order();
    t_multi();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule